// File: doc/BRIEF.md
# Key-Protected Flash Command Sequence Table

This block holds the command sequences that a serial flash controller replays when it talks to a memory device. There are sixteen sequences. Each sequence has eight 16-bit instructions, packed two to a 32-bit word, so each sequence uses four words. Software loads the table through a simple register write and read bus. Loading works only while the table is unlocked.

Locking and unlocking use a two-step protocol. First, a magic key value is written to a key register. The very next bus write must then go to a lock-control register and carry a lock or unlock command. Any other write in between clears the armed key. After reset the table is locked, and sequence 0 already holds a basic command-read sequence, so the controller can fetch from flash before software touches the table.

A separate read port lets the sequencer fetch any single instruction, using a sequence index and a step index. This port has no clock delay.

Top module: `seqtab_regs`

## Requirements
- R1: After reset the table is locked. Sequence 0 holds the words 0x08180403, 0x00001C10, 0x00000000 and 0x00000000 in word order. All other words are zero.
- R2: Word w (0..3) of sequence n (0..15) sits at byte address 0x310 + 16*n + 4*w. Address bits [1:0] are ignored. A bus read of a table address returns the stored word with no clock delay.
- R3: A table write made while the table is locked is dropped. The stored word keeps its old value.
- R4: Writing 0x5AF05AF0 to address 0x300, and then, as the next bus write, writing to address 0x304 with bit 1 set and bit 0 clear, unlocks the table.
- R5: A lock-control write at 0x304 with bit 0 set, made right after a correct key write, locks the table. When bits 0 and 1 are both set, bit 0 wins.
- R6: The key stays armed across cycles with no bus write. Any bus write other than a correct key write disarms it. This includes a wrong value written to 0x300 and a write to any other address. A lock-control write made while disarmed has no effect.
- R7: The sequencer port returns the instruction at step s (0..7) of sequence q. This is bits [15:0] of word s/2 when s is even, and bits [31:16] when s is odd. The port has no clock delay.
- R8: A bus read outside the table range returns zero, including reads of 0x300 and 0x304. A write outside the table never changes table contents.
- R9: A table write made while unlocked is visible to both read paths from the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 12 | Byte address for both writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, no clock delay |
| seq_idx | input | 4 | Sequencer fetch: sequence number |
| step_idx | input | 3 | Sequencer fetch: instruction step within the sequence |
| seq_instr | output | 16 | Fetched instruction |

## Verification
A wrong lock or arm state shows at the ports as a table write that lands or is dropped against expectation. A read-back at the next negative edge exposes it, one cycle after the offending write. A decode or storage fault shows as a wrong word on bus_rdata, or a wrong instruction on seq_instr, as soon as that address or step index is presented. The bench therefore mixes random key, lock, table and unrelated writes with frequent read-back of both read paths, compared against a shadow model of the table and the key state.

// File: rtl/seqtab_pkg.sv
package seqtab_pkg;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_KEY  = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_TAB  = 2'd3
   } seqtab_sel_e;

   // Boot contents of sequence 0: command 0x03, three address bytes, read 16, stop.
   // Instruction layout: [15:10] operation, [9:8] lane code, [7:0] operand.
   function automatic logic [15:0] boot_instr(input int unsigned step);
      case (step)
         0: boot_instr = 16'h0403;
         1: boot_instr = 16'h0818;
         2: boot_instr = 16'h1C10;
         default: boot_instr = 16'h0000;
      endcase
   endfunction

endpackage

// File: rtl/seqtab_guard.sv
module seqtab_guard
   import seqtab_pkg::*;
#(
   parameter int          ADDR_W     = 12,
   parameter int          DATA_W     = 32,
   parameter int          KEY_OFS    = 'h300,
   parameter int          CTRL_OFS   = 'h304,
   parameter int          TAB_OFS    = 'h310,
   parameter int          TAB_BYTES  = 256,
   parameter logic [31:0] KEY_VALUE  = 32'h5AF05AF0,
   parameter int          LOCK_BIT   = 0,
   parameter int          UNLOCK_BIT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output seqtab_sel_e       sel,
   output logic              locked,
   output logic              tab_we
);

   localparam logic [ADDR_W:0] TAB_END = (ADDR_W+1)'(TAB_OFS + TAB_BYTES);

   logic [ADDR_W-1:0] addr_w;
   logic              armed;
   logic              key_hit;

   initial begin : p_param_check
      assert (LOCK_BIT != UNLOCK_BIT && LOCK_BIT < DATA_W && UNLOCK_BIT < DATA_W)
         else $error("seqtab_guard: bad command bit positions");
      assert (TAB_OFS + TAB_BYTES <= (1 << ADDR_W))
         else $error("seqtab_guard: table does not fit address space");
   end

   always_comb begin
      addr_w = bus_addr & ~ADDR_W'(3);
      if (addr_w == ADDR_W'(KEY_OFS))
         sel = SEL_KEY;
      else if (addr_w == ADDR_W'(CTRL_OFS))
         sel = SEL_CTRL;
      else if (addr_w >= ADDR_W'(TAB_OFS) && {1'b0, addr_w} < TAB_END)
         sel = SEL_TAB;
      else
         sel = SEL_NONE;
   end

   assign key_hit = (sel == SEL_KEY) && (bus_wdata == DATA_W'(KEY_VALUE));
   assign tab_we  = bus_wr && (sel == SEL_TAB) && !locked;

   // One-shot arm: cleared by any write that is not the key itself.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (bus_wr)
         armed <= key_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         locked <= 1'b1;
      else if (bus_wr && sel == SEL_CTRL && armed) begin
         if (bus_wdata[LOCK_BIT])
            locked <= 1'b1;
         else if (bus_wdata[UNLOCK_BIT])
            locked <= 1'b0;
      end
   end

   // R4: leaving the locked state requires the arm flag one cycle earlier
   a_r4_unlock_keyed: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(armed));
   // R5: entering the locked state requires the arm flag one cycle earlier
   a_r5_lock_keyed: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(armed));
   // R6: arming only ever follows a bus write
   a_r6_arm_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(bus_wr));

endmodule

// File: rtl/seqtab_store.sv
module seqtab_store
   import seqtab_pkg::*;
#(
   parameter int NUM_WORDS = 64,
   parameter int WPS       = 4,
   parameter int DATA_W    = 32,
   parameter int INSTR_W   = 16,
   parameter int IDX_W     = $clog2(NUM_WORDS)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [IDX_W-1:0]                 widx,
   input  logic [DATA_W-1:0]                wdata,
   output logic [NUM_WORDS-1:0][DATA_W-1:0] words
);

   initial begin : p_param_check
      assert (INSTR_W >= 16 && DATA_W == 2 * INSTR_W)
         else $error("seqtab_store: word must hold exactly two instructions");
   end

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
      localparam int SQ = g / WPS;
      localparam int WD = g % WPS;
      localparam logic [DATA_W-1:0] RST_VAL = (SQ == 0) ?
         DATA_W'({INSTR_W'(boot_instr(2 * WD + 1)), INSTR_W'(boot_instr(2 * WD))}) :
         '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[g] <= RST_VAL;
         else if (we && widx == IDX_W'(g))
            words[g] <= wdata;
      end
   end

   // R3: with no permitted write the whole table holds still
   a_r3_hold_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(words));

endmodule

// File: rtl/seqtab_fetch.sv
module seqtab_fetch #(
   parameter int NUM_SEQ = 16,
   parameter int WPS     = 4,
   parameter int DATA_W  = 32,
   parameter int INSTR_W = 16,
   parameter int SEQ_W   = $clog2(NUM_SEQ),
   parameter int STEP_W  = $clog2(2 * WPS)
) (
   input  logic [NUM_SEQ*WPS-1:0][DATA_W-1:0] words,
   input  logic [SEQ_W-1:0]                   seq_idx,
   input  logic [STEP_W-1:0]                  step_idx,
   output logic [INSTR_W-1:0]                 instr
);

   localparam int IDX_W = SEQ_W + STEP_W - 1;

   logic [DATA_W-1:0] word;

   initial begin : p_param_check
      assert ((1 << SEQ_W) == NUM_SEQ && (1 << STEP_W) == 2 * WPS)
         else $error("seqtab_fetch: counts must be powers of two");
   end

   assign word = words[IDX_W'({seq_idx, step_idx[STEP_W-1:1]})];

   // Even steps live in the low half of a word, odd steps in the high half.
   always_comb begin
      if (step_idx[0])
         instr = word[2*INSTR_W-1:INSTR_W];
      else
         instr = word[INSTR_W-1:0];
   end

endmodule

// File: rtl/seqtab_regs.sv
module seqtab_regs
   import seqtab_pkg::*;
#(
   parameter int          ADDR_W    = 12,
   parameter int          DATA_W    = 32,
   parameter int          INSTR_W   = 16,
   parameter int          NUM_SEQ   = 16,
   parameter int          WPS       = 4,
   parameter int          KEY_OFS   = 'h300,
   parameter int          CTRL_OFS  = 'h304,
   parameter int          TAB_OFS   = 'h310,
   parameter logic [31:0] KEY_VALUE = 32'h5AF05AF0,
   localparam int         SEQ_W     = $clog2(NUM_SEQ),
   localparam int         STEP_W    = $clog2(2 * WPS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [SEQ_W-1:0]   seq_idx,
   input  logic [STEP_W-1:0]  step_idx,
   output logic [INSTR_W-1:0] seq_instr
);

   localparam int NUM_WORDS = NUM_SEQ * WPS;
   localparam int IDX_W     = $clog2(NUM_WORDS);
   localparam int TAB_BYTES = NUM_WORDS * (DATA_W / 8);

   seqtab_sel_e                    sel;
   logic                           locked;
   logic                           tab_we;
   logic [IDX_W-1:0]               tab_idx;
   logic [NUM_WORDS-1:0][DATA_W-1:0] words;

   initial begin : p_param_check
      assert (DATA_W == 32) else $error("seqtab_regs: bus must be 32 bits");
      assert (KEY_OFS % 4 == 0 && CTRL_OFS % 4 == 0 && TAB_OFS % 4 == 0)
         else $error("seqtab_regs: offsets must be word aligned");
   end

   assign tab_idx = IDX_W'((bus_addr - ADDR_W'(TAB_OFS)) >> 2);

   seqtab_guard #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_OFS(KEY_OFS), .CTRL_OFS(CTRL_OFS),
      .TAB_OFS(TAB_OFS), .TAB_BYTES(TAB_BYTES), .KEY_VALUE(KEY_VALUE),
      .LOCK_BIT(0), .UNLOCK_BIT(1)
   ) i_guard (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .sel(sel), .locked(locked), .tab_we(tab_we)
   );

   seqtab_store #(
      .NUM_WORDS(NUM_WORDS), .WPS(WPS), .DATA_W(DATA_W), .INSTR_W(INSTR_W), .IDX_W(IDX_W)
   ) i_store (
      .clk(clk), .rst_n(rst_n), .we(tab_we), .widx(tab_idx), .wdata(bus_wdata),
      .words(words)
   );

   seqtab_fetch #(
      .NUM_SEQ(NUM_SEQ), .WPS(WPS), .DATA_W(DATA_W), .INSTR_W(INSTR_W),
      .SEQ_W(SEQ_W), .STEP_W(STEP_W)
   ) i_fetch (
      .words(words), .seq_idx(seq_idx), .step_idx(step_idx), .instr(seq_instr)
   );

   assign bus_rdata = (sel == SEL_TAB) ? words[tab_idx] : '0;

   // R9: a permitted table write lands in the addressed word at the next edge
   a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      tab_we |=> words[$past(tab_idx)] == $past(bus_wdata));
   // R3: a locked table never sees a write enable
   a_r3_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> !tab_we);

endmodule

// File: tb/test_seqtab_regs.sv
module test_seqtab_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  seq_idx = '0;
   logic [2:0]  step_idx = '0;
   logic [15:0] seq_instr;

   int checks = 0;
   int errors = 0;

   logic [31:0] mdl [64];
   logic        m_locked;
   logic        m_armed;

   always #2 clk = ~clk;

   seqtab_regs i_seqtab_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seq_idx(seq_idx),
      .step_idx(step_idx), .seq_instr(seq_instr)
   );

   function automatic logic [31:0] boot_word(input int w);
      case (w)
         0: boot_word = 32'h08180403;
         1: boot_word = 32'h00001C10;
         default: boot_word = 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      int aw = int'(a) & ~3;
      if (aw >= 'h310 && aw < 'h410) exp_read = mdl[(aw - 'h310) >> 2];
      else exp_read = '0;
   endfunction

   function automatic logic [15:0] exp_instr(input int q, input int s);
      logic [31:0] w = mdl[q * 4 + s / 2];
      exp_instr = (s % 2 == 1) ? w[31:16] : w[15:0];
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 64; i++) mdl[i] = (i < 4) ? boot_word(i) : 32'h0;
      m_locked = 1'b1;
      m_armed  = 1'b0;
   endtask

   task automatic model_write(input logic [11:0] a, input logic [31:0] d);
      int  aw = int'(a) & ~3;
      logic was_armed = m_armed;
      m_armed = (aw == 'h300) && (d == 32'h5AF05AF0);
      if (aw == 'h304 && was_armed) begin
         if (d[0]) m_locked = 1'b1;
         else if (d[1]) m_locked = 1'b0;
      end
      if (aw >= 'h310 && aw < 'h410 && !m_locked) mdl[(aw - 'h310) >> 2] = d;
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic read_chk(input string req, input logic [11:0] a);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp_read(a));
   endtask

   task automatic fetch_chk(input string req, input int q, input int s);
      @(negedge clk);
      seq_idx = 4'(q); step_idx = 3'(s);
      #1;
      chk(req, {16'h0, seq_instr}, {16'h0, exp_instr(q, s)});
   endtask

   task automatic full_readback(input string req);
      for (int i = 0; i < 64; i++) read_chk(req, 12'('h310 + 4 * i));
   endtask

   initial begin : watchdog
      #(200000 * 4);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'd4242));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset contents and boot sequence
      full_readback("R1");
      for (int s = 0; s < 8; s++) fetch_chk("R7", 0, s);

      // R3: locked write dropped
      bus_write(12'h310, 32'hDEADBEEF);
      read_chk("R3", 12'h310);
      bus_write(12'h3FC, 32'h12345678);
      read_chk("R3", 12'h3FC);

      // R6: control write without key ignored
      bus_write(12'h304, 32'h2);
      bus_write(12'h320, 32'hAAAA5555);
      read_chk("R6", 12'h320);

      // R4 + R6: key survives idle cycles, then unlock
      bus_write(12'h300, 32'h5AF05AF0);
      idle(); idle(); idle();
      bus_write(12'h304, 32'h2);
      bus_write(12'h320, 32'hCAFEF00D);
      read_chk("R4", 12'h320);
      read_chk("R9", 12'h320);
      fetch_chk("R7", 1, 0);
      fetch_chk("R7", 1, 1);

      // R2: low address bits ignored
      bus_write(12'h333, 32'h0BADC0DE);
      read_chk("R2", 12'h330);
      read_chk("R2", 12'h331);

      // R8: reads outside the table return zero; writes outside leave table
      read_chk("R8", 12'h300);
      read_chk("R8", 12'h304);
      read_chk("R8", 12'h000);
      read_chk("R8", 12'h410);
      bus_write(12'h410, 32'hFFFFFFFF);
      read_chk("R8", 12'h40C);

      // R6: wrong key value then lock command does nothing
      bus_write(12'h300, 32'h5AF05AF1);
      bus_write(12'h304, 32'h1);
      bus_write(12'h3A0, 32'h11112222);
      read_chk("R6", 12'h3A0);

      // R6: intervening write disarms
      bus_write(12'h300, 32'h5AF05AF0);
      bus_write(12'h100, 32'h0);
      bus_write(12'h304, 32'h1);
      bus_write(12'h3A4, 32'h33334444);
      read_chk("R6", 12'h3A4);

      // R5: both bits set, lock wins
      bus_write(12'h300, 32'h5AF05AF0);
      bus_write(12'h304, 32'h3);
      bus_write(12'h3A8, 32'h55556666);
      read_chk("R5", 12'h3A8);

      // Random mix
      for (int n = 0; n < 1500; n++) begin
         int r = int'($urandom % 8);
         case (r)
            0: bus_write(12'h300, 32'h5AF05AF0);
            1: bus_write(12'h300, $urandom);
            2: bus_write(12'h304, 32'($urandom % 4));
            3, 4, 5: bus_write(12'('h310 + ($urandom % 256)), $urandom);
            6: bus_write(12'(($urandom % 'h300)), $urandom);
            default: idle();
         endcase
         if (n % 20 == 0) begin
            read_chk("R9", 12'('h310 + 4 * ($urandom % 64)));
            fetch_chk("R7", int'($urandom % 16), int'($urandom % 8));
         end
      end
      full_readback("R2");
      for (int q = 0; q < 16; q++) fetch_chk("R7", q, q % 8);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule